// File: doc/BRIEF.md
# Ping-pong frame receive buffer

This block sits between a byte-serial frame receiver and a processor's register interface. It holds two frame stores of eleven bytes each. At any time one store belongs to the bus side and the other belongs to the CPU side. The bus side fills its store one byte strobe at a time. It marks the store full at end-of-frame and raises a one-cycle receive interrupt. When the CPU-side store is empty and the bus-side store is full, the two stores exchange roles on the next clock. The CPU reads its store in one of two ways. The first is as a FIFO through data address 0, where an internal read pointer advances on each read. The second is by byte address, which leaves the pointer unchanged. A release strobe from the CPU marks its store empty.

The bus-side sequencer has three states. RX_IDLE waits for a start indication. From RX_IDLE, a start moves to RX_RECV when the bus-side store can be filled. A start moves to RX_DROP when both stores are full and overwrite is disabled. RX_RECV moves back to RX_IDLE on end-of-frame (completion) or on break (abort). A new start while in RX_RECV restarts the frame and the state stays RX_RECV. RX_DROP discards bytes and returns to RX_IDLE on end-of-frame or break. A break seen in RX_IDLE raises the break flag and the state stays RX_IDLE.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, both stores are empty. `cpu_count`, `cpu_rdptr` and `cpu_rdata` are 0. `rx_busy`, `break_rcvd`, `msg_lost` and `rx_irq` are 0.
- R2: Bytes strobed between start and end-of-frame are stored in arrival order. In the cycle after the end-of-frame cycle, the bus-side store is full and `rx_irq` is high for exactly one cycle.
- R3: When the CPU-side store is empty and the bus-side store is full, the roles swap one cycle later. After the swap, `cpu_buf_full`=1, `bus_buf_full`=0, `cpu_count` equals the frame length and `cpu_rdptr`=0.
- R4: A FIFO read is a read with `cpu_fifo_mode`=1 and `cpu_addr`=0. It returns the byte at `cpu_rdptr` in `cpu_rdata` one cycle later, and the pointer then increments. Once the pointer equals `cpu_count`, a FIFO read returns 0 and the pointer does not move.
- R5: Any other read is a random read. It returns the byte at `cpu_addr`, or 0 if `cpu_addr` >= `cpu_count`, and it leaves `cpu_rdptr` unchanged.
- R6: A `cpu_done` pulse empties the CPU-side store and zeroes its count and pointer in the next cycle. If the bus-side store is full, the swap of R3 follows one cycle after that.
- R7: Suppose both stores are full and `cfg_ovwr_en`=0 when a new frame starts. The frame is dropped, `msg_lost` becomes 1, no interrupt is raised, and neither store changes.
- R8: Suppose both stores are full and `cfg_ovwr_en`=1 when a new frame starts. The new frame replaces the bus-side store's contents and raises `rx_irq`.
- R9: Only the first 11 bytes of a frame are kept. Any further bytes are discarded and the count stays at 11.
- R10: `rx_busy` is high from the cycle after an accepted or dropped start until the cycle after end-of-frame or break.
- R11: A break sets `break_rcvd` and abandons the frame in progress. The store is not marked full and no interrupt is raised. `cpu_done` clears both `break_rcvd` and `msg_lost`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sof | input | 1 | Start of a frame on the bus side |
| bus_byte_vld | input | 1 | Strobe for one received byte |
| bus_byte | input | 8 | Received byte value |
| bus_eof | input | 1 | End of the current frame |
| bus_break | input | 1 | Break symbol seen; abandons the frame |
| cfg_ovwr_en | input | 1 | 1: a new frame may replace an unread full bus-side store |
| cpu_fifo_mode | input | 1 | 1: reads at address 0 use the auto-incrementing pointer |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_addr | input | 4 | CPU byte address |
| cpu_done | input | 1 | CPU release strobe for its store |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| cpu_count | output | 4 | Bytes held in the CPU-side store |
| cpu_rdptr | output | 4 | FIFO read pointer of the CPU-side store |
| cpu_buf_full | output | 1 | CPU-side store holds a frame |
| bus_buf_full | output | 1 | Bus-side store holds a complete frame |
| rx_busy | output | 1 | A frame is being received or dropped |
| break_rcvd | output | 1 | Sticky break flag |
| msg_lost | output | 1 | Sticky lost-frame flag |
| rx_irq | output | 1 | One-cycle pulse per completed frame |

## Verification
The bench sends a frame while the CPU store is full, then sends another while both stores are full. It does this once with overwrite disabled and once with it enabled. A design that wrote into the CPU's store, or that dropped the frame regardless of the enable, would return the wrong bytes on the later reads.

A FIFO read past the count must return 0 and leave the pointer where it is. A design that let the pointer run on would index outside the frame.

A twelve-byte frame must read back as exactly eleven bytes. A release must reach the pending frame one cycle later. A break must leave a partial frame that never appears as full and never raises an interrupt. If these went wrong, the counts or flags seen at the ports would not match.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
    localparam int FRAME_BYTES = 11;
    localparam int BYTE_W      = 8;
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1);

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_DROP = 2'd2
    } rx_state_t;
endpackage

// File: rtl/rxpp_bank.sv
// One frame store: byte array plus its fill count.
module rxpp_bank #(
    parameter int DEPTH = rxpp_pkg::FRAME_BYTES,
    parameter int DW    = rxpp_pkg::BYTE_W,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [CW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (clr) begin
            count <= '0;
        end else if (wr_en && (count < LIMIT)) begin
            mem[count] <= wr_data;
            count      <= count + 1'b1;
        end
    end

    always_comb begin
        rd_data = (rd_idx < LIMIT) ? mem[rd_idx] : '0;
    end
endmodule

// File: rtl/rxpp_ctrl.sv
// Bus-side sequencer, store ownership and status flags.
module rxpp_ctrl
    import rxpp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sof,
    input  logic       byte_vld,
    input  logic       eof,
    input  logic       brk,
    input  logic       ovwr_en,
    input  logic       cpu_done,
    output logic       cpu_sel,
    output logic [1:0] full,
    output logic [1:0] bank_clr,
    output logic       bus_wr_en,
    output logic       swap_now,
    output logic       rx_irq,
    output logic       msg_lost,
    output logic       break_rcvd,
    output logic       rx_busy
);
    rx_state_t state_q, state_d;
    logic next_sel;
    logic accept, drop, finish, abort;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and events
    always_comb begin
        swap_now = !full[cpu_sel] && full[~cpu_sel];
        next_sel = swap_now ? ~cpu_sel : cpu_sel;
        state_d  = state_q;
        accept   = 1'b0;
        drop     = 1'b0;
        finish   = 1'b0;
        abort    = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (brk) begin
                    abort = 1'b1;
                end else if (sof) begin
                    if (full[~next_sel] && !ovwr_en) begin
                        drop    = 1'b1;
                        state_d = RX_DROP;
                    end else begin
                        accept  = 1'b1;
                        state_d = RX_RECV;
                    end
                end
            end
            RX_RECV: begin
                if (brk) begin
                    abort   = 1'b1;
                    state_d = RX_IDLE;
                end else if (sof) begin
                    accept = 1'b1;
                end else if (eof) begin
                    finish  = 1'b1;
                    state_d = RX_IDLE;
                end
            end
            RX_DROP: begin
                if (brk) begin
                    abort   = 1'b1;
                    state_d = RX_IDLE;
                end else if (eof) begin
                    state_d = RX_IDLE;
                end
            end
            default: state_d = RX_IDLE;
        endcase
        bus_wr_en = (state_q == RX_RECV) && byte_vld && !brk;
        for (int i = 0; i < 2; i++) begin
            bank_clr[i] = (accept && (1'(i) == ~next_sel)) ||
                          (cpu_done && (1'(i) == cpu_sel));
        end
    end

    // outputs and ownership
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_sel    <= 1'b0;
            full       <= '0;
            rx_irq     <= 1'b0;
            msg_lost   <= 1'b0;
            break_rcvd <= 1'b0;
        end else begin
            cpu_sel <= next_sel;
            for (int i = 0; i < 2; i++) begin
                if (finish && (1'(i) == ~cpu_sel)) begin
                    full[i] <= 1'b1;
                end else if (accept && (1'(i) == ~next_sel)) begin
                    full[i] <= 1'b0;
                end else if (cpu_done && (1'(i) == cpu_sel)) begin
                    full[i] <= 1'b0;
                end
            end
            rx_irq <= finish;
            if (drop) begin
                msg_lost <= 1'b1;
            end else if (cpu_done) begin
                msg_lost <= 1'b0;
            end
            if (abort) begin
                break_rcvd <= 1'b1;
            end else if (cpu_done) begin
                break_rcvd <= 1'b0;
            end
        end
    end

    assign rx_busy = (state_q != RX_IDLE);
endmodule

// File: rtl/rxpp_rdport.sv
// CPU read path: FIFO pointer and registered read data.
module rxpp_rdport #(
    parameter int DW = rxpp_pkg::BYTE_W,
    parameter int CW = rxpp_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_mode,
    input  logic          rd,
    input  logic [CW-1:0] addr,
    input  logic [CW-1:0] count,
    input  logic          ptr_clr,
    input  logic [DW-1:0] bank_data,
    output logic [CW-1:0] rd_idx,
    output logic [CW-1:0] rdptr,
    output logic [DW-1:0] rdata
);
    logic fifo_hit, in_range;

    always_comb begin
        fifo_hit = fifo_mode && (addr == '0);
        rd_idx   = fifo_hit ? rdptr : addr;
        in_range = rd_idx < count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdptr <= '0;
            rdata <= '0;
        end else begin
            if (ptr_clr) begin
                rdptr <= '0;
            end else if (rd && fifo_hit && in_range) begin
                rdptr <= rdptr + 1'b1;
            end
            if (rd) begin
                rdata <= in_range ? bank_data : '0;
            end
        end
    end
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf #(
    parameter int DEPTH = rxpp_pkg::FRAME_BYTES,
    parameter int DW    = rxpp_pkg::BYTE_W,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sof,
    input  logic          bus_byte_vld,
    input  logic [DW-1:0] bus_byte,
    input  logic          bus_eof,
    input  logic          bus_break,
    input  logic          cfg_ovwr_en,
    input  logic          cpu_fifo_mode,
    input  logic          cpu_rd,
    input  logic [CW-1:0] cpu_addr,
    input  logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output logic [CW-1:0] cpu_count,
    output logic [CW-1:0] cpu_rdptr,
    output logic          cpu_buf_full,
    output logic          bus_buf_full,
    output logic          rx_busy,
    output logic          break_rcvd,
    output logic          msg_lost,
    output logic          rx_irq
);
    localparam int NBANK = 2;

    logic          cpu_sel;
    logic [1:0]    full;
    logic [1:0]    bank_clr;
    logic          bus_wr_en;
    logic          swap_now;
    logic [CW-1:0] rd_idx;
    logic [CW-1:0] bank_cnt [NBANK];
    logic [DW-1:0] bank_rd  [NBANK];

    rxpp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (bus_sof),
        .byte_vld   (bus_byte_vld),
        .eof        (bus_eof),
        .brk        (bus_break),
        .ovwr_en    (cfg_ovwr_en),
        .cpu_done   (cpu_done),
        .cpu_sel    (cpu_sel),
        .full       (full),
        .bank_clr   (bank_clr),
        .bus_wr_en  (bus_wr_en),
        .swap_now   (swap_now),
        .rx_irq     (rx_irq),
        .msg_lost   (msg_lost),
        .break_rcvd (break_rcvd),
        .rx_busy    (rx_busy)
    );

    for (genvar i = 0; i < NBANK; i++) begin : g_bank
        rxpp_bank #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (bank_clr[i]),
            .wr_en   (bus_wr_en && (1'(i) == ~cpu_sel)),
            .wr_data (bus_byte),
            .rd_idx  (rd_idx),
            .rd_data (bank_rd[i]),
            .count   (bank_cnt[i])
        );
    end

    rxpp_rdport #(.DW(DW), .CW(CW)) u_rdport (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (cpu_fifo_mode),
        .rd        (cpu_rd),
        .addr      (cpu_addr),
        .count     (bank_cnt[cpu_sel]),
        .ptr_clr   (swap_now || cpu_done),
        .bank_data (bank_rd[cpu_sel]),
        .rd_idx    (rd_idx),
        .rdptr     (cpu_rdptr),
        .rdata     (cpu_rdata)
    );

    assign cpu_count    = bank_cnt[cpu_sel];
    assign cpu_buf_full = full[cpu_sel];
    assign bus_buf_full = full[~cpu_sel];
endmodule

// File: rtl/rx_pingpong_buf_chk.sv
module rx_pingpong_buf_chk #(
    parameter int DEPTH = rxpp_pkg::FRAME_BYTES,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_irq,
    input logic          rx_busy,
    input logic          cpu_buf_full,
    input logic          bus_buf_full,
    input logic          cpu_done,
    input logic          cpu_rd,
    input logic          cpu_fifo_mode,
    input logic [CW-1:0] cpu_addr,
    input logic [CW-1:0] cpu_rdptr,
    input logic [CW-1:0] cpu_count,
    input logic          swap_now
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |=> !rx_irq); // R2
    AST_IRQ_HAS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> (cpu_buf_full || bus_buf_full)); // R2
    AST_SWAP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (!cpu_buf_full && bus_buf_full) |=> cpu_buf_full); // R3
    AST_PTR_WITHIN: assert property (@(posedge clk) disable iff (!rst_n) cpu_rdptr <= cpu_count); // R4
    AST_RANDOM_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n) (cpu_rd && !(cpu_fifo_mode && cpu_addr == '0) && !cpu_done && !swap_now) |=> $stable(cpu_rdptr)); // R5
    AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (cpu_done && cpu_buf_full) |=> !cpu_buf_full); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cpu_count <= CW'(DEPTH)); // R9
    AST_IDLE_AT_IRQ: assert property (@(posedge clk) disable iff (!rst_n) rx_irq |-> !rx_busy); // R10
endmodule

bind rx_pingpong_buf rx_pingpong_buf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/rx_pingpong_buf_test.sv
module rx_pingpong_buf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sof = 0, bus_byte_vld = 0, bus_eof = 0, bus_break = 0;
    logic [7:0] bus_byte = '0;
    logic       cfg_ovwr_en = 0, cpu_fifo_mode = 0, cpu_rd = 0, cpu_done = 0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_rdata;
    logic [3:0] cpu_count, cpu_rdptr;
    logic       cpu_buf_full, bus_buf_full, rx_busy, break_rcvd, msg_lost, rx_irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic rd_q = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    rx_pingpong_buf uut (.*);

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input string what, input int act, input int exp);
        chk(act == exp, tag, what, act, exp);
    endtask

    // scoreboard monitor
    always @(posedge clk) rd_q <= cpu_rd;
    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                chk(0, "R4", "unexpected read", int'(cpu_rdata), 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk_eq(t, "read data", int'(cpu_rdata), int'(e));
            end
        end
    end

    // driver: issue one read and queue its expected byte
    task automatic cpu_read(input bit fifo, input int addr, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cpu_fifo_mode = fifo;
        cpu_addr      = 4'(addr);
        cpu_rd        = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] base, input bit with_break);
        @(negedge clk);
        bus_sof = 1'b1;
        @(negedge clk);
        bus_sof = 1'b0;
        chk_eq("R10", "busy after start", int'(rx_busy), 1);
        for (int k = 0; k < n; k++) begin
            bus_byte_vld = 1'b1;
            bus_byte     = base + 8'(k);
            @(negedge clk);
        end
        bus_byte_vld = 1'b0;
        if (with_break) bus_break = 1'b1;
        else            bus_eof   = 1'b1;
        @(negedge clk);
        bus_break = 1'b0;
        bus_eof   = 1'b0;
    endtask

    task automatic release_buf();
        @(negedge clk);
        cpu_done = 1'b1;
        @(negedge clk);
        cpu_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1", "cpu_count", int'(cpu_count), 0);
        chk_eq("R1", "cpu_rdptr", int'(cpu_rdptr), 0);
        chk_eq("R1", "cpu_rdata", int'(cpu_rdata), 0);
        chk_eq("R1", "flags", int'({cpu_buf_full, bus_buf_full, rx_busy, break_rcvd, msg_lost, rx_irq}), 0);

        // R2 R3: frame A of 5 bytes, swaps to CPU side
        send_frame(5, 8'h10, 0);
        chk_eq("R2", "irq after eof", int'(rx_irq), 1);
        chk_eq("R10", "busy after eof", int'(rx_busy), 0);
        @(negedge clk);
        chk_eq("R2", "irq single pulse", int'(rx_irq), 0);
        chk_eq("R3", "cpu full after swap", int'(cpu_buf_full), 1);
        chk_eq("R3", "bus empty after swap", int'(bus_buf_full), 0);
        chk_eq("R3", "count after swap", int'(cpu_count), 5);
        chk_eq("R3", "ptr after swap", int'(cpu_rdptr), 0);

        // R4 FIFO reads
        for (int k = 0; k < 5; k++) cpu_read(1, 0, 8'h10 + 8'(k), "R4");
        cpu_read(1, 0, 8'h00, "R4");
        @(negedge clk);
        chk_eq("R4", "ptr stops at count", int'(cpu_rdptr), 5);

        // R5 random reads
        cpu_read(0, 3, 8'h13, "R5");
        cpu_read(0, 0, 8'h10, "R5");
        cpu_read(0, 7, 8'h00, "R5");
        cpu_read(1, 2, 8'h12, "R5");
        @(negedge clk);
        chk_eq("R5", "ptr unchanged", int'(cpu_rdptr), 5);

        // R9: 12-byte frame B while CPU store full
        send_frame(12, 8'h20, 0);
        chk_eq("R2", "irq frame B", int'(rx_irq), 1);
        @(negedge clk);
        chk_eq("R2", "bus store full", int'(bus_buf_full), 1);
        chk_eq("R3", "no swap while cpu full", int'(cpu_count), 5);

        // R7: frame C dropped
        cfg_ovwr_en = 1'b0;
        send_frame(3, 8'h30, 0);
        chk_eq("R7", "no irq on drop", int'(rx_irq), 0);
        chk_eq("R7", "msg_lost", int'(msg_lost), 1);
        chk_eq("R7", "cpu store kept", int'(cpu_count), 5);

        // R6 release then swap
        release_buf();
        chk_eq("R6", "cpu empty after done", int'(cpu_buf_full), 0);
        chk_eq("R6", "count zero after done", int'(cpu_count), 0);
        chk_eq("R11", "msg_lost cleared", int'(msg_lost), 0);
        @(negedge clk);
        chk_eq("R6", "swap after release", int'(cpu_buf_full), 1);
        chk_eq("R9", "count saturates", int'(cpu_count), 11);
        chk_eq("R6", "bus empty", int'(bus_buf_full), 0);
        for (int k = 0; k < 11; k++) cpu_read(1, 0, 8'h20 + 8'(k), "R9");
        cpu_read(1, 0, 8'h00, "R9");

        // R8: overwrite enabled
        send_frame(2, 8'h40, 0);
        cfg_ovwr_en = 1'b1;
        send_frame(3, 8'h50, 0);
        chk_eq("R8", "irq on overwrite", int'(rx_irq), 1);
        chk_eq("R8", "no msg_lost", int'(msg_lost), 0);
        release_buf();
        @(negedge clk);
        chk_eq("R8", "replaced count", int'(cpu_count), 3);
        for (int k = 0; k < 3; k++) cpu_read(1, 0, 8'h50 + 8'(k), "R8");

        // R11: break aborts frame
        send_frame(2, 8'h70, 1);
        chk_eq("R11", "break flag", int'(break_rcvd), 1);
        chk_eq("R11", "no irq on break", int'(rx_irq), 0);
        chk_eq("R10", "busy clears on break", int'(rx_busy), 0);
        chk_eq("R11", "bus not full", int'(bus_buf_full), 0);
        release_buf();
        chk_eq("R11", "break cleared", int'(break_rcvd), 0);
        @(negedge clk);
        chk_eq("R11", "no swap of partial", int'(cpu_buf_full), 0);
        send_frame(1, 8'h60, 0);
        @(negedge clk);
        chk_eq("R2", "new frame count", int'(cpu_count), 1);
        cpu_read(1, 0, 8'h60, "R2");
        repeat (3) @(negedge clk);
        chk_eq("R4", "scoreboard drained", exp_q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule